// File: doc/BRIEF.md
# Two-Axis Raster Scan Sequencer

This block steps a two-axis position across a grid of points, laid out as a number of lines with a number of samples on each line. At every point it sends the new X coordinate and then the new Y coordinate to two digital-to-analog converter links. It then waits a programmable settling time and triggers a chosen group of analog-to-digital converters at the same time. After the conversions it hands each enabled result to a memory-write port, one value per transfer.

Within a line the position moves by a signed step vector. At the end of each line it moves by a second signed vector. The block captures all scan settings when `arm` rises, so software can change the inputs during a scan without affecting it. Every external link uses the same arm/finished handshake. The converter links and the address generator for the memory writes sit outside the block.

Top module: `raster_seq`

## Requirements
- R1: The block captures the sample count, line count, settle time, both step vectors and the converter mask when `arm` rises while it is idle. Changing those inputs later has no effect on the scan in progress.
- R2: The first point is (0,0). After each sample of a line except the last, the in-line vector (`step_x_in`, `step_y_in`) is added to the position. After the last sample of every line except the last line, the line vector (`line_x_in`, `line_y_in`) is added instead. Coordinates wrap as 20-bit two's complement. A count input of 0 is treated as 1.
- R3: Each DAC word is 24 bits. The upper nibble is the write code 4'b0001 and the lower 20 bits are the coordinate. At each point the X word is issued before the Y word, and the two DAC requests are never active together.
- R4: Two consecutive DAC requests on either channel start at least 10 clock cycles apart, counted between the rising edges of their arm signals.
- R5: The converter arms rise exactly `settle_in`+1 clock cycles after the Y DAC arm falls.
- R6: At each point all converters whose mask bit is 1 are armed in the same cycle, and no other converter is ever armed. With a zero mask, no converter is armed and nothing is written.
- R7: Each 18-bit converter result is sign-extended to 24 bits before it is written.
- R8: Each point's results are written after all of its conversions have completed, one per memory handshake, in ascending converter index order. The written data stays stable while the request is pending.
- R9: Every request holds its arm high until the matching finished is seen and drops it in the next cycle. A new request starts only while that finished is low.
- R10: `running` is high from the cycle after the capture until the last write of the last point is acknowledged. `done` is then high until `arm` is low, after which the block is idle. `running` and `done` are never high together.
- R11: After reset, `running`, `done` and every arm output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Rising edge starts a scan; must fall before the next one |
| samples_in | input | 9 | Samples per line (0 treated as 1) |
| lines_in | input | 9 | Number of lines (0 treated as 1) |
| settle_in | input | 4 | Extra wait cycles after each move |
| step_x_in | input | 20 | Signed X increment within a line |
| step_y_in | input | 20 | Signed Y increment within a line |
| line_x_in | input | 20 | Signed X increment between lines |
| line_y_in | input | 20 | Signed Y increment between lines |
| adc_mask_in | input | 9 | One enable bit per converter |
| running | output | 1 | Scan in progress |
| done | output | 1 | Scan complete, held until arm is low |
| dac_x_arm | output | 1 | X DAC request |
| dac_x_word | output | 24 | X DAC command word |
| dac_x_fin | input | 1 | X DAC finished |
| dac_y_arm | output | 1 | Y DAC request |
| dac_y_word | output | 24 | Y DAC command word |
| dac_y_fin | input | 1 | Y DAC finished |
| adc_arm | output | 9 | Per-converter conversion request |
| adc_data | input | 162 | Packed 18-bit results, converter i at bits [18i+17:18i] |
| adc_fin | input | 9 | Per-converter finished |
| mem_arm | output | 1 | Memory write request |
| mem_data | output | 24 | Sign-extended result to write |
| mem_fin | input | 1 | Memory write finished |

## Verification
The assertions assume that every responder obeys the handshake. A responder raises finished only while its arm is high and keeps it high until the arm drops. It also clears each converter's finished before that converter is armed again. The bench responders keep to this rule. They wait one to three cycles before raising finished and clear it on the first sampled cycle with the arm low. Each converter's result is stable before its finished rises.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SET_X,
      ST_SET_Y,
      ST_SETTLE,
      ST_SAMPLE,
      ST_STORE,
      ST_NEXT,
      ST_DONE
   } scan_state_e;

   localparam logic [3:0] DAC_OP_WRITE = 4'b0001;

endpackage

// File: rtl/rs_req_port.sv
`timescale 1ns/1ps
// Generic requester side of an arm/finished handshake with a latched payload.
module rs_req_port #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [W-1:0] payload_in,
   input  logic         fin,
   output logic         arm,
   output logic [W-1:0] payload,
   output logic         ready,
   output logic         ack
);
   logic         arm_q;
   logic [W-1:0] pay_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         pay_q <= '0;
      end else if (fire) begin
         arm_q <= 1'b1;
         pay_q <= payload_in;
      end else if (arm_q && fin) begin
         arm_q <= 1'b0;
      end
   end

   assign arm     = arm_q;
   assign payload = pay_q;
   assign ready   = !arm_q && !fin;
   assign ack     = arm_q && fin;
endmodule

// File: rtl/rs_cmd_spacer.sv
`timescale 1ns/1ps
// Enforces a minimum number of cycles between consecutive command starts.
module rs_cmd_spacer #(
   parameter int GAP = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic ok
);
   generate
      if (GAP == 0) begin : g_free
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ fire;
         assign ok = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(GAP + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= CW'(GAP);
            end else if (fire) begin
               cnt <= '0;
            end else if (cnt != CW'(GAP)) begin
               cnt <= cnt + 1'b1;
            end
         end
         assign ok = (cnt == CW'(GAP));
      end
   endgenerate
endmodule

// File: rtl/rs_adc_bank.sv
`timescale 1ns/1ps
// Per-converter arm and capture with sign extension of the result.
module rs_adc_bank #(
   parameter int N      = 9,
   parameter int RAW_W  = 18,
   parameter int DATA_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [N-1:0]        mask,
   input  logic [N*RAW_W-1:0]  data_in,
   input  logic [N-1:0]        fin,
   output logic [N-1:0]        arm,
   output logic [N*DATA_W-1:0] res,
   output logic                busy
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_ch
         logic [RAW_W-1:0]  raw;
         logic [DATA_W-1:0] ext;
         logic              a_q;
         logic [DATA_W-1:0] r_q;

         assign raw = data_in[g*RAW_W +: RAW_W];
         if (DATA_W == RAW_W) begin : g_same
            assign ext = raw;
         end else begin : g_sext
            assign ext = {{(DATA_W-RAW_W){raw[RAW_W-1]}}, raw};
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_q <= 1'b0;
               r_q <= '0;
            end else if (start && mask[g]) begin
               a_q <= 1'b1;
            end else if (a_q && fin[g]) begin
               a_q <= 1'b0;
               r_q <= ext;
            end
         end

         assign arm[g]                   = a_q;
         assign res[g*DATA_W +: DATA_W]  = r_q;
      end
   endgenerate

   assign busy = |arm;
endmodule

// File: rtl/rs_pick_lowest.sv
`timescale 1ns/1ps
// Index of the lowest set bit of a vector.
module rs_pick_lowest #(
   parameter int N = 9,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/raster_seq.sv
`timescale 1ns/1ps
module raster_seq
   import raster_pkg::*;
#(
   parameter int CNT_W     = 9,
   parameter int SETTLE_W  = 4,
   parameter int COORD_W   = 20,
   parameter int CMD_W     = 4,
   parameter int NUM_ADC   = 9,
   parameter int ADC_RAW_W = 18,
   parameter int DATA_W    = 24,
   parameter int DAC_GAP   = 10,
   localparam int DAC_W    = CMD_W + COORD_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         arm,
   input  logic [CNT_W-1:0]             samples_in,
   input  logic [CNT_W-1:0]             lines_in,
   input  logic [SETTLE_W-1:0]          settle_in,
   input  logic signed [COORD_W-1:0]    step_x_in,
   input  logic signed [COORD_W-1:0]    step_y_in,
   input  logic signed [COORD_W-1:0]    line_x_in,
   input  logic signed [COORD_W-1:0]    line_y_in,
   input  logic [NUM_ADC-1:0]           adc_mask_in,
   output logic                         running,
   output logic                         done,
   output logic                         dac_x_arm,
   output logic [DAC_W-1:0]             dac_x_word,
   input  logic                         dac_x_fin,
   output logic                         dac_y_arm,
   output logic [DAC_W-1:0]             dac_y_word,
   input  logic                         dac_y_fin,
   output logic [NUM_ADC-1:0]           adc_arm,
   input  logic [NUM_ADC*ADC_RAW_W-1:0] adc_data,
   input  logic [NUM_ADC-1:0]           adc_fin,
   output logic                         mem_arm,
   output logic [DATA_W-1:0]            mem_data,
   input  logic                         mem_fin
);
   localparam int IDX_W = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1;

   generate
      if (CMD_W < 4) begin : g_bad_cmd
         $error("raster_seq: CMD_W must hold the 4-bit write code");
      end
      if (ADC_RAW_W > DATA_W) begin : g_bad_data
         $error("raster_seq: ADC_RAW_W must not exceed DATA_W");
      end
      if (NUM_ADC < 1 || CNT_W < 1 || SETTLE_W < 1) begin : g_bad_size
         $error("raster_seq: counts and widths must be positive");
      end
   endgenerate

   scan_state_e                state;
   logic                       arm_q;
   logic [CNT_W-1:0]           smp_lim, line_lim, s_cnt, l_cnt;
   logic [SETTLE_W-1:0]        settle_q, settle_cnt;
   logic signed [COORD_W-1:0]  stx, sty, lnx, lny, pos_x, pos_y;
   logic [NUM_ADC-1:0]         mask_q, pend_q;

   logic x_fire, x_ready, x_ack, y_fire, y_ready, y_ack, gap_ok;
   logic adc_start, adc_busy;
   logic [NUM_ADC*DATA_W-1:0]  adc_res;
   logic pend_any;
   logic [IDX_W-1:0] pend_idx;
   logic mem_fire, mem_ready, mem_ack;

   // Command spacing shared by both DAC channels
   rs_cmd_spacer #(.GAP(DAC_GAP)) u_spacer (
      .clk(clk), .rst_n(rst_n), .fire(x_fire | y_fire), .ok(gap_ok)
   );

   assign x_fire = (state == ST_SET_X) && x_ready && gap_ok;
   assign y_fire = (state == ST_SET_Y) && y_ready && gap_ok;

   rs_req_port #(.W(DAC_W)) u_dac_x (
      .clk(clk), .rst_n(rst_n), .fire(x_fire),
      .payload_in({CMD_W'(DAC_OP_WRITE), pos_x}), .fin(dac_x_fin),
      .arm(dac_x_arm), .payload(dac_x_word), .ready(x_ready), .ack(x_ack)
   );

   rs_req_port #(.W(DAC_W)) u_dac_y (
      .clk(clk), .rst_n(rst_n), .fire(y_fire),
      .payload_in({CMD_W'(DAC_OP_WRITE), pos_y}), .fin(dac_y_fin),
      .arm(dac_y_arm), .payload(dac_y_word), .ready(y_ready), .ack(y_ack)
   );

   assign adc_start = (state == ST_SETTLE) && (settle_cnt == '0);

   rs_adc_bank #(.N(NUM_ADC), .RAW_W(ADC_RAW_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .start(adc_start), .mask(mask_q),
      .data_in(adc_data), .fin(adc_fin), .arm(adc_arm), .res(adc_res),
      .busy(adc_busy)
   );

   rs_pick_lowest #(.N(NUM_ADC)) u_pick (
      .vec(pend_q), .any(pend_any), .idx(pend_idx)
   );

   assign mem_fire = (state == ST_STORE) && pend_any && mem_ready;

   rs_req_port #(.W(DATA_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .fire(mem_fire),
      .payload_in(adc_res[int'(pend_idx)*DATA_W +: DATA_W]), .fin(mem_fin),
      .arm(mem_arm), .payload(mem_data), .ready(mem_ready), .ack(mem_ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         arm_q      <= 1'b0;
         smp_lim    <= '0;
         line_lim   <= '0;
         s_cnt      <= '0;
         l_cnt      <= '0;
         settle_q   <= '0;
         settle_cnt <= '0;
         stx        <= '0;
         sty        <= '0;
         lnx        <= '0;
         lny        <= '0;
         pos_x      <= '0;
         pos_y      <= '0;
         mask_q     <= '0;
         pend_q     <= '0;
      end else begin
         arm_q <= arm;
         case (state)
            ST_IDLE: begin
               if (arm && !arm_q) begin
                  smp_lim  <= (samples_in == '0) ? '0 : samples_in - 1'b1;
                  line_lim <= (lines_in == '0) ? '0 : lines_in - 1'b1;
                  settle_q <= settle_in;
                  stx      <= step_x_in;
                  sty      <= step_y_in;
                  lnx      <= line_x_in;
                  lny      <= line_y_in;
                  mask_q   <= adc_mask_in;
                  pos_x    <= '0;
                  pos_y    <= '0;
                  s_cnt    <= '0;
                  l_cnt    <= '0;
                  state    <= ST_SET_X;
               end
            end
            ST_SET_X: begin
               if (x_ack) state <= ST_SET_Y;
            end
            ST_SET_Y: begin
               if (y_ack) begin
                  settle_cnt <= settle_q;
                  state      <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_cnt == '0) state <= ST_SAMPLE;
               else settle_cnt <= settle_cnt - 1'b1;
            end
            ST_SAMPLE: begin
               if (!adc_busy) begin
                  pend_q <= mask_q;
                  state  <= ST_STORE;
               end
            end
            ST_STORE: begin
               if (!pend_any) state <= ST_NEXT;
               else if (mem_ack) pend_q[pend_idx] <= 1'b0;
            end
            ST_NEXT: begin
               if (s_cnt != smp_lim) begin
                  s_cnt <= s_cnt + 1'b1;
                  pos_x <= pos_x + stx;
                  pos_y <= pos_y + sty;
                  state <= ST_SET_X;
               end else if (l_cnt != line_lim) begin
                  s_cnt <= '0;
                  l_cnt <= l_cnt + 1'b1;
                  pos_x <= pos_x + lnx;
                  pos_y <= pos_y + lny;
                  state <= ST_SET_X;
               end else begin
                  state <= ST_DONE;
               end
            end
            ST_DONE: begin
               if (!arm) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign running = (state != ST_IDLE) && (state != ST_DONE);
   assign done    = (state == ST_DONE);
endmodule

// File: rtl/raster_seq_chk.sv
`timescale 1ns/1ps
module raster_seq_chk #(
   parameter int GAP     = 10,
   parameter int NUM_ADC = 9,
   parameter int DAC_W   = 24,
   parameter int CMD_W   = 4,
   parameter int DATA_W  = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               dac_x_arm,
   input logic               dac_x_fin,
   input logic [DAC_W-1:0]   dac_x_word,
   input logic               dac_y_arm,
   input logic               dac_y_fin,
   input logic [DAC_W-1:0]   dac_y_word,
   input logic [NUM_ADC-1:0] adc_arm,
   input logic [NUM_ADC-1:0] mask_q,
   input logic               mem_arm,
   input logic               mem_fin,
   input logic [DATA_W-1:0]  mem_data,
   input logic               running,
   input logic               done
);
   localparam int CW = $clog2(GAP + 2);
   logic          x_prev, y_prev, dac_rise;
   logic [CW-1:0] since;

   assign dac_rise = (dac_x_arm && !x_prev) || (dac_y_arm && !y_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_prev <= 1'b0;
         y_prev <= 1'b0;
         since  <= CW'(GAP);
      end else begin
         x_prev <= dac_x_arm;
         y_prev <= dac_y_arm;
         if (dac_rise) since <= '0;
         else if (since < CW'(GAP)) since <= since + 1'b1;
      end
   end

   // R4: command spacing between DAC requests
   p_dac_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dac_rise |-> (int'(since) >= GAP - 1));

   // R3: one DAC channel at a time, write code in the upper nibble
   p_one_dac_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(dac_x_arm && dac_y_arm));
   p_x_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_x_arm |-> (dac_x_word[DAC_W-1 -: CMD_W] == CMD_W'(4'b0001)));
   p_y_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dac_y_arm |-> (dac_y_word[DAC_W-1 -: CMD_W] == CMD_W'(4'b0001)));

   // R9: arms held until finished and released right after
   p_x_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_x_arm && !dac_x_fin) |=> dac_x_arm);
   p_y_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_y_arm && dac_y_fin) |=> !dac_y_arm);
   p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_arm && !mem_fin) |=> mem_arm);
   p_mem_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_arm && mem_fin) |=> !mem_arm);

   // R6: only enabled converters are armed
   p_adc_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_arm & ~mask_q) == '0);

   // R8: writes follow completed conversions with stable data
   p_store_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_arm |-> (adc_arm == '0));
   p_mem_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_arm && !mem_fin) |=> $stable(mem_data));

   // R10: status outputs
   p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(running && done));
   p_busy_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_x_arm || dac_y_arm || mem_arm || (adc_arm != '0)) |-> running);
endmodule

bind raster_seq raster_seq_chk #(
   .GAP(DAC_GAP), .NUM_ADC(NUM_ADC), .DAC_W(DAC_W), .CMD_W(CMD_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .dac_x_arm(dac_x_arm), .dac_x_fin(dac_x_fin), .dac_x_word(dac_x_word),
   .dac_y_arm(dac_y_arm), .dac_y_fin(dac_y_fin), .dac_y_word(dac_y_word),
   .adc_arm(adc_arm), .mask_q(mask_q),
   .mem_arm(mem_arm), .mem_fin(mem_fin), .mem_data(mem_data),
   .running(running), .done(done)
);

// File: tb/raster_seq_bench.sv
`timescale 1ns/1ps
module raster_seq_bench;
   localparam int GAP = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic [8:0] samples_in = '0, lines_in = '0, adc_mask_in = '0;
   logic [3:0] settle_in = '0;
   logic signed [19:0] step_x_in = '0, step_y_in = '0, line_x_in = '0, line_y_in = '0;
   logic running, done, dac_x_arm, dac_y_arm, mem_arm;
   logic [23:0] dac_x_word, dac_y_word, mem_data;
   logic dac_x_fin = 1'b0, dac_y_fin = 1'b0, mem_fin = 1'b0;
   logic [8:0] adc_arm;
   logic [8:0] adc_fin = '0;
   logic [161:0] adc_data = '0;

   int checks = 0;
   int errors = 0;
   int pt = 0;
   int cycle = 0;
   int exp_settle = 0;
   logic [8:0] exp_mask = '0;
   bit finished_run = 1'b0;
   logic [23:0] exp_x[$];
   logic [23:0] exp_y[$];
   logic [23:0] exp_mem[$];

   raster_seq u_raster_seq (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .samples_in(samples_in), .lines_in(lines_in), .settle_in(settle_in),
      .step_x_in(step_x_in), .step_y_in(step_y_in),
      .line_x_in(line_x_in), .line_y_in(line_y_in),
      .adc_mask_in(adc_mask_in), .running(running), .done(done),
      .dac_x_arm(dac_x_arm), .dac_x_word(dac_x_word), .dac_x_fin(dac_x_fin),
      .dac_y_arm(dac_y_arm), .dac_y_word(dac_y_word), .dac_y_fin(dac_y_fin),
      .adc_arm(adc_arm), .adc_data(adc_data), .adc_fin(adc_fin),
      .mem_arm(mem_arm), .mem_data(mem_data), .mem_fin(mem_fin)
   );

   initial forever #2 clk = ~clk;

   function automatic logic [17:0] raw_val(int p, int i);
      int v;
      v = p * 4099 + i * 131 - 20000;
      return v[17:0];
   endfunction

   function automatic logic [23:0] sext(logic [17:0] r);
      return {{6{r[17]}}, r};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // DAC responders: finished two cycles after arm, cleared when arm drops
   initial begin
      int cx = 0;
      forever begin
         @(negedge clk);
         if (dac_x_arm && !dac_x_fin) begin
            cx++;
            if (cx >= 2) begin dac_x_fin = 1'b1; cx = 0; end
         end else if (!dac_x_arm) dac_x_fin = 1'b0;
      end
   end

   initial begin
      int cy = 0;
      forever begin
         @(negedge clk);
         if (dac_y_arm && !dac_y_fin) begin
            cy++;
            if (cy >= 2) begin dac_y_fin = 1'b1; cy = 0; end
         end else if (!dac_y_arm) dac_y_fin = 1'b0;
      end
   end

   // Converter responder: data set at the arm, finished after 1..3 cycles
   initial begin
      int cnt[9];
      logic [8:0] prev = '0;
      for (int i = 0; i < 9; i++) cnt[i] = 0;
      forever begin
         @(negedge clk);
         if (adc_arm != '0 && prev == '0) begin
            for (int i = 0; i < 9; i++)
               if (adc_arm[i]) adc_data[i*18 +: 18] = raw_val(pt, i);
            pt++;
         end
         for (int i = 0; i < 9; i++) begin
            if (adc_arm[i] && !adc_fin[i]) begin
               cnt[i]++;
               if (cnt[i] >= 1 + i % 3) begin adc_fin[i] = 1'b1; cnt[i] = 0; end
            end else if (!adc_arm[i]) adc_fin[i] = 1'b0;
         end
         prev = adc_arm;
      end
   end

   // Memory responder: alternating one- and three-cycle latency
   initial begin
      int cm = 0;
      int nw = 0;
      forever begin
         @(negedge clk);
         if (mem_arm && !mem_fin) begin
            cm++;
            if (cm >= ((nw % 2 == 0) ? 1 : 3)) begin mem_fin = 1'b1; cm = 0; nw++; end
         end else if (!mem_arm) mem_fin = 1'b0;
      end
   end

   // Per-cycle monitor against the reference queues
   initial begin
      logic px = 1'b0, py = 1'b0, pm = 1'b0;
      logic [8:0] pa = '0;
      int last_dac = -100;
      int y_fall = 0;
      int xs = 0, ys = 0;
      forever begin
         @(negedge clk);
         #1;
         cycle++;
         if (dac_x_arm && !px) begin
            if (exp_x.size() == 0) chk(1'b0, "R2 unexpected X word", dac_x_word, 0);
            else begin
               chk(dac_x_word == exp_x[0], "R2/R3 X word", dac_x_word, exp_x[0]);
               void'(exp_x.pop_front());
            end
            chk(cycle - last_dac >= GAP, "R4 DAC spacing", cycle - last_dac, GAP);
            last_dac = cycle;
            xs++;
         end
         if (dac_y_arm && !py) begin
            if (exp_y.size() == 0) chk(1'b0, "R2 unexpected Y word", dac_y_word, 0);
            else begin
               chk(dac_y_word == exp_y[0], "R2/R3 Y word", dac_y_word, exp_y[0]);
               void'(exp_y.pop_front());
            end
            chk(xs == ys + 1, "R3 X before Y", ys, xs - 1);
            chk(cycle - last_dac >= GAP, "R4 DAC spacing", cycle - last_dac, GAP);
            last_dac = cycle;
            ys++;
         end
         if (!dac_y_arm && py) y_fall = cycle;
         if (adc_arm != '0 && pa == '0) begin
            chk(adc_arm == exp_mask, "R6 armed set", adc_arm, exp_mask);
            chk(cycle - y_fall == exp_settle + 1, "R5 settle delay",
                cycle - y_fall, exp_settle + 1);
         end
         if (mem_arm && !pm) begin
            if (exp_mem.size() == 0) chk(1'b0, "R6 unexpected write", mem_data, 0);
            else begin
               chk(mem_data == exp_mem[0], "R7/R8 written value", mem_data, exp_mem[0]);
               void'(exp_mem.pop_front());
            end
            chk(adc_arm == '0, "R8 write after conversions", adc_arm, 0);
         end
         if (dac_x_arm || dac_y_arm || mem_arm || adc_arm != '0)
            chk(running, "R10 running while busy", running, 1);
         px = dac_x_arm; py = dac_y_arm; pm = mem_arm; pa = adc_arm;
      end
   end

   task automatic run_scan(input int ns, input int nl, input int st,
                           input int sx, input int sy, input int lx, input int ly,
                           input logic [8:0] m);
      int es, el, p, n;
      logic signed [19:0] qx, qy;
      es = (ns == 0) ? 1 : ns;
      el = (nl == 0) ? 1 : nl;
      qx = '0; qy = '0; p = 0;
      for (int l = 0; l < el; l++) begin
         for (int s = 0; s < es; s++) begin
            exp_x.push_back({4'b0001, qx});
            exp_y.push_back({4'b0001, qy});
            if (m != '0) begin
               for (int i = 0; i < 9; i++)
                  if (m[i]) exp_mem.push_back(sext(raw_val(p, i)));
               p++;
            end
            if (s < es - 1) begin qx = qx + 20'(sx); qy = qy + 20'(sy); end
         end
         if (l < el - 1) begin qx = qx + 20'(lx); qy = qy + 20'(ly); end
      end
      exp_settle = st;
      exp_mask = m;
      pt = 0;
      @(negedge clk);
      samples_in = 9'(ns); lines_in = 9'(nl); settle_in = 4'(st);
      step_x_in = 20'(sx); step_y_in = 20'(sy);
      line_x_in = 20'(lx); line_y_in = 20'(ly);
      adc_mask_in = m;
      arm = 1'b1;
      repeat (3) @(negedge clk);
      // R1: scramble every setting while the scan runs
      samples_in = 9'h1FF; lines_in = 9'h1FF; settle_in = 4'd9;
      step_x_in = 20'h12345; step_y_in = 20'h54321;
      line_x_in = 20'hABCDE; line_y_in = 20'h0F0F0;
      adc_mask_in = ~m;
      n = 0;
      while (!done && n < 30000) begin @(negedge clk); n++; end
      chk(done == 1'b1, "R10 done after last write", done, 1);
      chk(running == 1'b0, "R10 running low when done", running, 0);
      chk(exp_x.size() == 0, "R1/R2 remaining X points", exp_x.size(), 0);
      chk(exp_y.size() == 0, "R1/R2 remaining Y points", exp_y.size(), 0);
      chk(exp_mem.size() == 0, "R1/R6 remaining writes", exp_mem.size(), 0);
      repeat (4) @(negedge clk);
      chk(done == 1'b1, "R10 done held while arm high", done, 1);
      arm = 1'b0;
      repeat (2) @(negedge clk);
      chk(done == 1'b0 && running == 1'b0, "R10 idle after arm low",
          {done, running}, 0);
      exp_x.delete(); exp_y.delete(); exp_mem.delete();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!running && !done, "R11 status after reset", {running, done}, 0);
      chk(!dac_x_arm && !dac_y_arm && !mem_arm && adc_arm == '0,
          "R11 arms after reset", {dac_x_arm, dac_y_arm, mem_arm, adc_arm}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!running && !done, "R11 idle before arm", {running, done}, 0);
      // mixed mask, two lines, small signed vectors
      run_scan(3, 2, 2, 5, -3, -10, 7, 9'b100100101);
      // R6: empty mask, no conversions and no writes
      run_scan(2, 2, 0, 1, 1, 100, -100, 9'b000000000);
      // R2: zero counts act as one point, all converters, longest settle
      run_scan(0, 0, 15, 7, 7, 7, 7, 9'h1FF);
      // R2/R7: coordinate wrap on one line, highest converter only
      run_scan(4, 1, 1, 200000, -200000, 0, 0, 9'b100000000);
      finished_run = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished_run) begin
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule